// File: doc/BRIEF.md
# Self-Timed Programming Sequencer with Pin Status

This block runs the internal programming cycle of a small serial non-volatile memory. The command decoder grants a write-type command and hands it over with a one-clock strobe. The strobe carries an operation code, an address and a data word, and the block latches them. When chip select next falls, the block starts a cycle of fixed length, which it times by counting system clocks. During that cycle it drives a memory write port, or a protect-boundary write port, or a one-shot lock pulse.

The status of the cycle is shown on the serial data output itself, and only while chip select is high. A 0 means the cycle is still running and a 1 means it has finished. No serial clock is needed to read the status, and chip select may be toggled freely without disturbing the cycle. The ready indication stays until one of two things clears it: a start bit (DI high on a serial clock rising edge while selected), or chip select falling. After that the output is released again. All pins are sampled on the system clock.

Top module: `seq_prog`

## Requirements
- R1: A `cmd_valid` strobe is latched only when `busy` is low and `cmd_op` is one of 0 (single write), 1 (all-array write), 2 (protect clear), 3 (protect set) or 4 (protect lock). Codes 5 to 7, and any strobe while busy, are dropped, and a later chip-select fall then starts nothing.
- R2: `busy` rises on the clock after the one that samples a chip-select fall with a command latched. It stays high for exactly `WR_CYCLES` clocks.
- R3: A single write pulses `mem_we` for one clock, in the first busy clock, with the latched address and data.
- R4: An all-array write asserts `mem_we` for each of the first 2^AW busy clocks. The address steps up from 0 by one each clock and the data is the latched word.
- R5: In the first busy clock, a protect clear pulses `prot_we` with `prot_wdata` all ones, a protect set pulses `prot_we` with the latched address, and a protect lock pulses `lock_we`. Each pulse lasts one clock.
- R6: While `busy` is high and `cs` is high, `do_oe` is 1 and `do_val` is 0, with no serial clock needed. Toggling `cs` during the cycle changes neither its length nor its writes.
- R7: After the cycle ends, `cs` high gives `do_oe`=1 and `do_val`=1. This holds however long `cs` stayed low before being raised.
- R8: An `sk` rising edge sampled with `di`=1 and `cs` high clears the ready indication. A `cs` fall also clears it. Once cleared, `do_oe` stays 0. An `sk` edge with `di`=0 leaves the indication in place.
- R9: With `cs` low, `do_oe` is 0.
- R10: A chip-select fall that starts a new cycle while ready is still shown clears the ready indication and starts the new cycle on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Granted command strobe |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_addr | input | AW | Command address |
| cmd_data | input | DW | Command data word |
| cs | input | 1 | Chip select, sampled |
| sk | input | 1 | Serial clock, sampled |
| di | input | 1 | Serial data in, sampled |
| busy | output | 1 | Programming cycle running |
| do_val | output | 1 | Status value on serial output |
| do_oe | output | 1 | Serial output drive enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |
| prot_we | output | 1 | Protect boundary write enable |
| prot_wdata | output | AW | Protect boundary value |
| lock_we | output | 1 | Protect lock pulse |

## Verification
Two actions can fall on the same clock edge: clearing the ready indication and starting a new cycle. Both are triggered by a chip-select fall. The bench provokes this by leaving ready shown with `cs` high, strobing a fresh command without any serial clock, and then dropping `cs`. It judges the result by requiring `busy` on the next clock and `do_val`=0 once `cs` is raised again. Random chip-select toggling and command strobes during busy cycles also check that neither a fall nor a strobe alters a running cycle.

// File: rtl/seq_prog.sv
module seq_prog #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int WR_CYCLES = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  output logic          busy,
  output logic          do_val,
  output logic          do_oe,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          prot_we,
  output logic [AW-1:0] prot_wdata,
  output logic          lock_we
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);
  localparam logic [2:0] OP_WR = 3'd0, OP_ALL = 3'd1, OP_CLR = 3'd2,
                         OP_SET = 3'd3, OP_LOCK = 3'd4;

  logic          pend, rdy, cs_q, sk_q;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt;

  wire cs_fall   = cs_q & ~cs;
  wire start     = pend & cs_fall;
  wire done      = busy & (cnt == LAST);
  wire start_bit = cs & sk & ~sk_q & di;
  wire accept    = cmd_valid & ~busy & (cmd_op <= OP_LOCK);
  wire first     = busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; rdy <= 1'b0; busy <= 1'b0;
      cs_q <= 1'b0; sk_q <= 1'b0; cnt <= '0;
      op_q <= '0; addr_q <= '0; data_q <= '0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        pend <= 1'b0;
      end else if (accept) begin
        pend   <= 1'b1;
        op_q   <= cmd_op;
        addr_q <= cmd_addr;
        data_q <= cmd_data;
      end
      if (busy) begin
        if (done) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
      if (done)                       rdy <= 1'b1;
      else if (start_bit || cs_fall)  rdy <= 1'b0;
    end
  end

  assign do_oe      = cs & (busy | rdy);
  assign do_val     = ~busy;
  assign mem_we     = (first & (op_q == OP_WR)) |
                      (busy & (op_q == OP_ALL) & (cnt < CW'(DEPTH)));
  assign mem_addr   = (op_q == OP_ALL) ? cnt[AW-1:0] : addr_q;
  assign mem_wdata  = data_q;
  assign prot_we    = first & ((op_q == OP_CLR) | (op_q == OP_SET));
  assign prot_wdata = (op_q == OP_CLR) ? '1 : addr_q;
  assign lock_we    = first & (op_q == OP_LOCK);

  p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && cnt == '0);
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  p_ready_after_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rdy && !busy);
  p_no_latch_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pend);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && op_q == OP_WR |=> !mem_we);
  p_ready_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && !busy && start_bit |=> !rdy);
endmodule

// File: tb/tb_seq_prog.sv
module tb_seq_prog;
  localparam int AW = 8, DW = 16, W = 300, DEPTH = 1 << AW;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cs = 0, sk = 0, di = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [DW-1:0] cmd_data = 0;
  logic busy, do_val, do_oe, mem_we, prot_we, lock_we;
  logic [AW-1:0] mem_addr, prot_wdata;
  logic [DW-1:0] mem_wdata;
  int n_chk = 0, n_bad = 0, cyc = 0;

  seq_prog #(.AW(AW), .DW(DW), .WR_CYCLES(W)) dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_mem_we(int op, int i);
    return (op == 0 && i == 0) || (op == 1 && i < DEPTH);
  endfunction
  function automatic logic [AW-1:0] exp_mem_addr(int op, int i, logic [AW-1:0] a);
    return (op == 1) ? AW'(i) : a;
  endfunction
  function automatic logic [AW-1:0] exp_prot(int op, logic [AW-1:0] a);
    return (op == 2) ? '1 : a;
  endfunction

  // start a cycle, check every busy clock, show ready; clear it if asked
  task automatic run_cmd(int op, logic [AW-1:0] a, logic [DW-1:0] d, bit noisy, bit clr);
    cs = 1; cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
    tick;
    cmd_valid = 0; cs = 0;
    tick;
    for (int i = 0; i < W; i++) begin
      chk("R2 busy held", busy, 1);
      chk("R3/R4 mem_we", mem_we, exp_mem_we(op, i));
      if (exp_mem_we(op, i)) begin
        chk("R3/R4 mem_addr", mem_addr, exp_mem_addr(op, i, a));
        chk("R3/R4 mem_wdata", mem_wdata, d);
      end
      chk("R5 prot_we", prot_we, (i == 0) && (op == 2 || op == 3));
      if (i == 0 && (op == 2 || op == 3)) chk("R5 prot_wdata", prot_wdata, exp_prot(op, a));
      chk("R5 lock_we", lock_we, (i == 0) && (op == 4));
      chk("R6/R9 do_oe busy", do_oe, cs);
      if (cs) chk("R6 busy status", do_val, 0);
      if (noisy) begin
        cs = 1'($urandom);
        cmd_valid = 1'($urandom); cmd_op = 3'($urandom % 5); cmd_addr = 8'($urandom);
      end
      tick;
    end
    cmd_valid = 0;
    chk("R2 busy end", busy, 0);
    cs = 1; #1;
    chk("R7 ready oe", do_oe, 1);
    chk("R7 ready val", do_val, 1);
    tick;
    if (clr) begin
      cs = 0; tick;
      chk("R1 no latched cmd", busy, 0);
      cs = 1; #1;
      chk("R8 cleared by cs fall", do_oe, 0);
      cs = 0; tick;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick; tick;
    chk("R9 reset oe", do_oe, 0);
    chk("R2 reset busy", busy, 0);
    chk("R3 reset we", mem_we, 0);
    rst_n = 1; tick;

    // R1: undefined code ignored
    cs = 1; cmd_valid = 1; cmd_op = 3'd6; tick;
    cmd_valid = 0; cs = 0; tick; tick;
    chk("R1 bad code", busy, 0);

    run_cmd(0, 8'h5a, 16'hbeef, 0, 1);
    run_cmd(1, 8'h00, 16'h1234, 0, 1);
    run_cmd(2, 8'h00, 16'h0, 0, 1);
    run_cmd(3, 8'h40, 16'h0, 0, 1);
    run_cmd(4, 8'h00, 16'h0, 0, 1);

    // R7 ready persists while deselected; R8 start bit clearing
    run_cmd(0, 8'h11, 16'h2222, 1, 0);
    cs = 0; tick; tick; tick;
    cs = 1; #1;
    chk("R7 ready after cs low", do_oe, 0);
    cs = 0; tick;
    cs = 1; cmd_valid = 1; cmd_op = 0; tick; cmd_valid = 0; cs = 0; tick;
    repeat (W) tick;
    chk("R7 busy done", busy, 0);
    repeat (5) tick;
    cs = 1; #1;
    chk("R7 ready long after", do_val & do_oe, 1);
    tick;
    sk = 1; di = 0; tick; sk = 0; tick;
    chk("R8 zero bit keeps ready", do_oe, 1);
    di = 1; sk = 1; tick; sk = 0; di = 0;
    chk("R8 start bit clears", do_oe, 0);
    cs = 0; tick;

    // R10: new cycle starts on the same cs fall that clears ready
    run_cmd(3, 8'h80, 16'h0, 0, 0);
    cmd_valid = 1; cmd_op = 0; cmd_addr = 8'h33; cmd_data = 16'h4444; tick;
    cmd_valid = 0; cs = 0; tick;
    chk("R10 busy", busy, 1);
    chk("R10 write", mem_we, 1);
    cs = 1; #1;
    chk("R10 status busy", do_val, 0);
    chk("R10 status oe", do_oe, 1);
    for (int k = 0; k < W + 4 && busy; k++) tick;
    cs = 0; tick;

    // random commands with chip-select noise and ignored strobes
    for (int r = 0; r < 8; r++)
      run_cmd(int'($urandom % 5), 8'($urandom), 16'($urandom), 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule